// File: doc/BRIEF.md
# ECC Memory Controller Datapath

This block connects a 64-bit host request port to a 72-bit memory word port. It protects every stored quadword with a (72,64) SEC-DED Hamming code. On a write it computes eight check bits and stores them next to the data. On a read it recomputes the check bits, compares them with the stored ones, and then corrects the data, flags it, or passes it through, depending on two mode inputs. A write that enables only some of the eight bytes becomes a read, correct, merge, re-encode and write sequence, so the check bits always cover the whole quadword.

The host side handles one request at a time with a valid/ready handshake. Each accepted request returns exactly one response pulse. The memory side is a plain synchronous port with a fixed read latency of `RD_LAT` cycles and one write enable per byte lane. Every correctable or uncorrectable event raises a one-cycle pulse. The first event after a clear is recorded in sticky status: the failing address and the syndrome.

The controller has four states:
- `ST_IDLE` accepts a request and moves to one of two states. A full write, or any write while ECC is off, goes to `ST_WR_CMD`. A read, or a partial write while ECC is on, goes to `ST_RD_CMD`.
- `ST_RD_CMD` issues the memory read and always moves to `ST_RD_WAIT`.
- `ST_RD_WAIT` counts the read latency. When the word arrives it moves to one of two states. A read, or a merge whose old word cannot be corrected, goes back to `ST_IDLE`. A successful merge goes to `ST_WR_CMD`.
- `ST_WR_CMD` issues the memory write and always returns to `ST_IDLE`.

Top module: `ecc_mem_ctrl`

## Requirements
- R1: With `ecc_en` high, a write with all eight byte enables set issues one memory write and no read. The write enables all nine lanes and stores {overall, check[6:0], data[63:0]} in bits 71, 70:64 and 63:0. Check bit j is the XOR of the data bits whose code position has bit j set. Data bits take the code positions 3, 5, 6, 7, 9, ... in ascending order; these are the integers that are not powers of two. Bit 71 makes the parity of the whole word even.
- R2: A read of an undamaged word returns the stored data with `rsp_err` low and no event pulse.
- R3: With `ecc_en` and `corr_en` high, a read whose word has one flipped bit (any of the 72) returns the original data. `rsp_err` stays low and `ce_pulse` rises for exactly one cycle.
- R4: With `ecc_en` high, a read whose word has two flipped bits returns `rsp_err` high and one `ue_pulse`, and no `ce_pulse`.
- R5: With `ecc_en` high and `corr_en` low, reads return the raw stored data unmodified. A single-bit error still gives `ce_pulse`, and a double-bit error gives `ue_pulse` and `rsp_err`.
- R6: With `ecc_en` high, a write with some but not all byte enables set issues one memory read and then one full-width write. The write holds the re-encoded merge of the enabled new bytes with the old data, after any single-bit error in the old data has been corrected. Such a correction raises `ce_pulse`.
- R7: If the old word of a partial write is uncorrectable, no memory write is issued and memory is unchanged. The response has `rsp_err` high and `ue_pulse` is raised.
- R8: With `ecc_en` low, reads are unchecked: raw data, no pulses, `rsp_err` low. Writes go straight to memory with no read. Data lane b is enabled by byte enable b, and the check lane (bits 71:64) is written only when all eight byte enables are set.
- R9: `req_ready` is high only in the idle state. It stays low from acceptance until the response, so it covers the final memory write of a read-modify-write sequence.
- R10: `ce_seen` and `ue_seen` are sticky flags set by events and cleared by `stat_clr`. The first event after a clear captures `err_addr` and `err_syn` = {overall parity, check XOR[6:0]}. For a single data-bit error that value is {1, position of the bit}. Later events do not overwrite the capture.
- R11: Every accepted request produces exactly one `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_en | input | 1 | Enables check-bit checking and read-modify-write |
| corr_en | input | 1 | Enables data correction on host reads |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Quadword address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables for writes |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Uncorrectable error or aborted write |
| mem_en | output | 1 | Memory command strobe |
| mem_we | output | 1 | Memory command is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 72 | Encoded word to store |
| mem_lane_we | output | 9 | Per-lane write enables, lane 8 = check byte |
| mem_rdata | input | 72 | Word returned RD_LAT cycles after a read |
| ce_pulse | output | 1 | Correctable event pulse |
| ue_pulse | output | 1 | Uncorrectable event pulse |
| stat_clr | input | 1 | Clears sticky status |
| ce_seen | output | 1 | Sticky correctable flag |
| ue_seen | output | 1 | Sticky uncorrectable flag |
| err_addr | output | ADDR_W | Address of first logged event |
| err_syn | output | 8 | Syndrome of first logged event |

## Verification
The assertions assume three things about the inputs. First, `ecc_en` does not change while a request is in flight. Second, memory returns the word stored at the read address exactly `RD_LAT` cycles after the command. Third, no request is presented together with a status clear that overlaps another event. The stimulus meets these conditions in several ways. It changes the mode inputs only between completed requests, while the block is idle. It models storage as a lane-masked array with a fixed-depth read pipeline. It injects bit faults directly into that array only while no command is active.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    localparam int DATA_W = 64;
    localparam int BYTES  = DATA_W / 8;
    localparam int HAM_W  = 7;
    localparam int SYN_W  = HAM_W + 1;
    localparam int WORD_W = DATA_W + SYN_W;
    localparam int LANES  = WORD_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_CMD,
        ST_RD_WAIT,
        ST_WR_CMD
    } ctl_state_t;

    // Code position of data bit idx: the idx-th integer >= 3 that is not a power of two.
    function automatic int data_pos(input int idx);
        int pos;
        int seen;
        pos  = 0;
        seen = 0;
        for (int k = 3; k < (1 << HAM_W); k++) begin
            if ((k & (k - 1)) != 0) begin
                if (seen == idx) pos = k;
                seen++;
            end
        end
        return pos;
    endfunction

    // Data bits covered by check bit bitn.
    function automatic logic [DATA_W-1:0] col_mask(input int bitn);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (((data_pos(i) >> bitn) & 1) != 0) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/ecc_encode.sv
module ecc_encode
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [HAM_W-1:0]  chk
);
    for (genvar j = 0; j < HAM_W; j++) begin : g_chk
        localparam logic [DATA_W-1:0] MASK = col_mask(j);
        assign chk[j] = ^(data & MASK);
    end
endmodule

// File: rtl/ecc_check.sv
module ecc_check
    import ecc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [DATA_W-1:0] data_fix,
    output logic [SYN_W-1:0]  syn,
    output logic              single,
    output logic              multi
);
    logic [HAM_W-1:0] chk_r;
    logic [HAM_W-1:0] s;
    logic             p;

    ecc_encode u_recode (
        .data (word[DATA_W-1:0]),
        .chk  (chk_r)
    );

    assign s      = chk_r ^ word[DATA_W +: HAM_W];
    assign p      = ^word;
    assign single = p;
    assign multi  = !p && (s != '0);
    assign syn    = {p, s};

    for (genvar i = 0; i < DATA_W; i++) begin : g_fix
        localparam int P = data_pos(i);
        assign data_fix[i] = word[i] ^ (p && (s == HAM_W'(P)));
    end
endmodule

// File: rtl/ecc_merge.sv
module ecc_merge
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] upd,
    input  logic [BYTES-1:0]  be,
    output logic [DATA_W-1:0] merged
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign merged[b*8 +: 8] = be[b] ? upd[b*8 +: 8] : base[b*8 +: 8];
    end
endmodule

// File: rtl/ecc_mem_ctrl.sv
module ecc_mem_ctrl
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_en,
    input  logic              corr_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BYTES-1:0]  req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [LANES-1:0]  mem_lane_we,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              ce_pulse,
    output logic              ue_pulse,
    input  logic              stat_clr,
    output logic              ce_seen,
    output logic              ue_seen,
    output logic [ADDR_W-1:0] err_addr,
    output logic [SYN_W-1:0]  err_syn
);
    localparam int CNT_W = $clog2(RD_LAT + 1);

    ctl_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [BYTES-1:0]  be_q;
    logic              mode_ecc_q;
    logic              mode_corr_q;

    logic [HAM_W-1:0]  enc_chk;
    logic [DATA_W-1:0] rd_fix;
    logic [DATA_W-1:0] merged;
    logic [SYN_W-1:0]  rd_syn;
    logic              rd_single, rd_multi;
    logic              cap, ev_ce, ev_ue;
    logic              ce_keep, ue_keep;

    ecc_encode u_enc (
        .data (wdata_q),
        .chk  (enc_chk)
    );

    ecc_check u_chk (
        .word     (mem_rdata),
        .data_fix (rd_fix),
        .syn      (rd_syn),
        .single   (rd_single),
        .multi    (rd_multi)
    );

    ecc_merge u_mrg (
        .base   (rd_fix),
        .upd    (wdata_q),
        .be     (be_q),
        .merged (merged)
    );

    assign cap   = (state_q == ST_RD_WAIT) && (cnt_q == CNT_W'(RD_LAT));
    assign ev_ce = cap && mode_ecc_q && rd_single;
    assign ev_ue = cap && mode_ecc_q && rd_multi;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write && (!ecc_en || (&req_be))) state_d = ST_WR_CMD;
                    else                                     state_d = ST_RD_CMD;
                end
            end
            ST_RD_CMD:  state_d = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (cap) begin
                    if (!wr_q || rd_multi) state_d = ST_IDLE;
                    else                   state_d = ST_WR_CMD;
                end
            end
            ST_WR_CMD:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        mem_en      = (state_q == ST_RD_CMD) || (state_q == ST_WR_CMD);
        mem_we      = (state_q == ST_WR_CMD);
        mem_addr    = addr_q;
        mem_wdata   = {^{enc_chk, wdata_q}, enc_chk, wdata_q};
        mem_lane_we = '0;
        if (state_q == ST_WR_CMD) begin
            if (mode_ecc_q) mem_lane_we = '1;
            else            mem_lane_we = {(&be_q), be_q};
        end
    end

    // request capture, merge buffer, responses and pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            wr_q        <= 1'b0;
            addr_q      <= '0;
            wdata_q     <= '0;
            be_q        <= '0;
            mode_ecc_q  <= 1'b0;
            mode_corr_q <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            rsp_err     <= 1'b0;
            ce_pulse    <= 1'b0;
            ue_pulse    <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            ce_pulse  <= ev_ce;
            ue_pulse  <= ev_ue;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        wr_q        <= req_write;
                        addr_q      <= req_addr;
                        wdata_q     <= req_wdata;
                        be_q        <= req_be;
                        mode_ecc_q  <= ecc_en;
                        mode_corr_q <= corr_en;
                    end
                end
                ST_RD_CMD:  cnt_q <= CNT_W'(1);
                ST_RD_WAIT: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (cap) begin
                        if (!wr_q) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= mode_ecc_q && rd_multi;
                            rsp_rdata <= (mode_ecc_q && mode_corr_q) ? rd_fix
                                                                     : mem_rdata[DATA_W-1:0];
                        end else if (rd_multi) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                        end else begin
                            wdata_q   <= merged;
                        end
                    end
                end
                ST_WR_CMD: begin
                    rsp_valid <= 1'b1;
                    rsp_err   <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // sticky status
    assign ce_keep = ce_seen && !stat_clr;
    assign ue_keep = ue_seen && !stat_clr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_seen  <= 1'b0;
            ue_seen  <= 1'b0;
            err_addr <= '0;
            err_syn  <= '0;
        end else begin
            ce_seen <= ce_keep || ev_ce;
            ue_seen <= ue_keep || ev_ue;
            if ((ev_ce || ev_ue) && !(ce_keep || ue_keep)) begin
                err_addr <= addr_q;
                err_syn  <= rd_syn;
            end else if (stat_clr) begin
                err_addr <= '0;
                err_syn  <= '0;
            end
        end
    end
endmodule

// File: rtl/ecc_mem_ctrl_chk.sv
module ecc_mem_ctrl_chk
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ecc_en,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              mem_en,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [LANES-1:0]  mem_lane_we,
    input logic              ce_pulse,
    input logic              ue_pulse,
    input logic              stat_clr,
    input logic              ce_seen,
    input logic              ue_seen,
    input logic [ADDR_W-1:0] err_addr
);
    // R1
    even_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && ecc_en) |-> ((^mem_wdata) == 1'b0 && (&mem_lane_we)));

    // R9
    busy_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !req_ready);

    // R4
    err_has_ue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> ue_pulse);

    // R3
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce_pulse && ue_pulse));

    // R10
    ce_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_pulse |-> ce_seen);

    // R10
    ue_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ue_pulse |-> ue_seen);

    // R10
    clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> (!ce_seen || ce_pulse));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ce_seen || ue_seen) && !$past(stat_clr)) |-> $stable(err_addr));

    // R11
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind ecc_mem_ctrl ecc_mem_ctrl_chk #(.ADDR_W(ADDR_W)) u_ecc_mem_ctrl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ecc_en      (ecc_en),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .mem_lane_we (mem_lane_we),
    .ce_pulse    (ce_pulse),
    .ue_pulse    (ue_pulse),
    .stat_clr    (stat_clr),
    .ce_seen     (ce_seen),
    .ue_seen     (ue_seen),
    .err_addr    (err_addr)
);

// File: tb/ecc_mem_ctrl_bench.sv
module ecc_mem_ctrl_bench;
    import ecc_pkg::*;

    localparam int CLK_P = 10;
    localparam int AW    = 4;
    localparam int LAT   = 2;
    localparam int DEPTH = 1 << AW;

    logic              clk, rst_n, ecc_en, corr_en;
    logic              req_valid, req_ready, req_write;
    logic [AW-1:0]     req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic [BYTES-1:0]  req_be;
    logic              rsp_valid, rsp_err;
    logic [DATA_W-1:0] rsp_rdata;
    logic              mem_en, mem_we;
    logic [AW-1:0]     mem_addr;
    logic [WORD_W-1:0] mem_wdata, mem_rdata;
    logic [LANES-1:0]  mem_lane_we;
    logic              ce_pulse, ue_pulse, stat_clr, ce_seen, ue_seen;
    logic [AW-1:0]     err_addr;
    logic [SYN_W-1:0]  err_syn;

    logic              bd_en;
    logic [AW-1:0]     bd_addr;
    logic [WORD_W-1:0] bd_mask;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int rd_cnt, wr_cnt, ce_cnt, ue_cnt, rsp_cnt;
    int got_rd, got_wr, got_ce, got_ue, got_rsp;
    bit got_leak, got_timeout, got_err;
    logic [DATA_W-1:0] got_data;

    ecc_mem_ctrl #(.ADDR_W(AW), .RD_LAT(LAT)) u_ecc_mem_ctrl (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .corr_en(corr_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_lane_we(mem_lane_we), .mem_rdata(mem_rdata),
        .ce_pulse(ce_pulse), .ue_pulse(ue_pulse), .stat_clr(stat_clr),
        .ce_seen(ce_seen), .ue_seen(ue_seen), .err_addr(err_addr), .err_syn(err_syn)
    );

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    // storage model with lane masks, fault injection and a fixed-latency read pipe
    logic [WORD_W-1:0] mem_q  [DEPTH];
    logic [WORD_W-1:0] pipe_q [LAT];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (mem_en && mem_we) begin
                for (int l = 0; l < LANES; l++)
                    if (mem_lane_we[l]) mem_q[mem_addr][l*8 +: 8] <= mem_wdata[l*8 +: 8];
            end
            if (bd_en) mem_q[bd_addr] <= mem_q[bd_addr] ^ bd_mask;
        end
        if (mem_en && !mem_we) pipe_q[0] <= mem_q[mem_addr];
        for (int k = 1; k < LAT; k++) pipe_q[k] <= pipe_q[k-1];
    end
    assign mem_rdata = pipe_q[LAT-1];

    always @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= 0; wr_cnt <= 0; ce_cnt <= 0; ue_cnt <= 0; rsp_cnt <= 0;
        end else begin
            if (mem_en && !mem_we) rd_cnt <= rd_cnt + 1;
            if (mem_en && mem_we)  wr_cnt <= wr_cnt + 1;
            if (ce_pulse)  ce_cnt  <= ce_cnt + 1;
            if (ue_pulse)  ue_cnt  <= ue_cnt + 1;
            if (rsp_valid) rsp_cnt <= rsp_cnt + 1;
        end
    end

    // code position of data bit i: skip powers of two starting after 2
    function automatic int bpos(input int i);
        int k;
        k = 2;
        for (int c = 0; c <= i; c++) begin
            k++;
            while ((k & (k - 1)) == 0) k++;
        end
        return k;
    endfunction

    function automatic logic [WORD_W-1:0] benc(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] s;
        s = '0;
        for (int i = 0; i < DATA_W; i++) if (d[i]) s = s ^ HAM_W'(bpos(i));
        return {(^d) ^ (^s), s, d};
    endfunction

    function automatic logic [HAM_W-1:0] spos(input int b);
        if (b < DATA_W)      return HAM_W'(bpos(b));
        else if (b < 71)     return HAM_W'(1 << (b - DATA_W));
        else                 return '0;
    endfunction

    function automatic logic [DATA_W-1:0] pat(input int n);
        logic [31:0] a, b;
        a = 32'(n) * 32'h9E37_79B9;
        b = 32'(n + 7) * 32'h85EB_CA6B;
        return {a ^ 32'h0123_4567, b ^ 32'h89AB_CDEF};
    endfunction

    function automatic logic [DATA_W-1:0] mrg(input logic [DATA_W-1:0] base,
                                              input logic [DATA_W-1:0] upd,
                                              input logic [BYTES-1:0] be);
        logic [DATA_W-1:0] r;
        r = base;
        for (int b = 0; b < BYTES; b++) if (be[b]) r[b*8 +: 8] = upd[b*8 +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic do_req(input bit wr, input int addr,
                          input logic [DATA_W-1:0] data, input logic [BYTES-1:0] be);
        int r0, w0, c0, u0, v0, guard;
        @(negedge clk);
        req_write = wr;
        req_addr  = AW'(addr);
        req_wdata = data;
        req_be    = be;
        req_valid = 1'b1;
        r0 = rd_cnt; w0 = wr_cnt; c0 = ce_cnt; u0 = ue_cnt; v0 = rsp_cnt;
        got_leak = 0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!rsp_valid && guard < 40) begin
            if (req_ready) got_leak = 1;
            @(negedge clk);
            guard++;
        end
        got_timeout = (guard >= 40);
        got_data = rsp_rdata;
        got_err  = rsp_err;
        @(negedge clk);
        got_rd  = rd_cnt - r0;
        got_wr  = wr_cnt - w0;
        got_ce  = ce_cnt - c0;
        got_ue  = ue_cnt - u0;
        got_rsp = rsp_cnt - v0;
        chk(!got_timeout && got_rsp == 1, "R11 one response per request",
            WORD_W'(got_rsp), WORD_W'(1));
    endtask

    task automatic flip(input int addr, input logic [WORD_W-1:0] mask);
        @(negedge clk);
        bd_en = 1'b1; bd_addr = AW'(addr); bd_mask = mask;
        @(negedge clk);
        bd_en = 1'b0;
    endtask

    task automatic clear_status();
        @(negedge clk);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R11 actual=%0d expected=%0d", 0, 1);
            finish_up();
        end
    end

    initial begin : main
        logic [DATA_W-1:0] d, n, e;
        logic [WORD_W-1:0] m, old;
        rst_n = 0; ecc_en = 1; corr_en = 1; req_valid = 0; req_write = 0;
        req_addr = '0; req_wdata = '0; req_be = '0; stat_clr = 0;
        bd_en = 0; bd_addr = '0; bd_mask = '0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // reset state: R9, R10, R11
        chk(req_ready == 1'b1, "R9 ready after reset", WORD_W'(req_ready), WORD_W'(1));
        chk(rsp_valid == 1'b0 && mem_en == 1'b0, "R11 quiet after reset",
            WORD_W'({rsp_valid, mem_en}), '0);
        chk(!ce_seen && !ue_seen, "R10 status clear after reset",
            WORD_W'({ce_seen, ue_seen}), '0);

        // full writes and clean reads: R1, R2
        for (int a = 0; a < DEPTH; a++) begin
            d = pat(a);
            do_req(1, a, d, 8'hFF);
            chk(got_wr == 1 && got_rd == 0, "R1 full write has no read",
                WORD_W'({got_rd[7:0], got_wr[7:0]}), WORD_W'(16'h0001));
            chk(mem_q[a] == benc(d), "R1 stored word", mem_q[a], benc(d));
            do_req(0, a, '0, '0);
            chk(got_data == d && !got_err && got_ce == 0 && got_ue == 0, "R2 clean read",
                WORD_W'(got_data), WORD_W'(d));
        end

        // single-bit sweep over all 72 bits: R3, R10
        for (int b = 0; b < WORD_W; b++) begin
            d = pat(b + 100);
            m = WORD_W'(1) << b;
            do_req(1, b % DEPTH, d, 8'hFF);
            clear_status();
            flip(b % DEPTH, m);
            do_req(0, b % DEPTH, '0, '0);
            chk(got_data == d && !got_err, "R3 corrected data", WORD_W'(got_data), WORD_W'(d));
            chk(got_ce == 1 && got_ue == 0, "R3 one ce pulse",
                WORD_W'({got_ce[7:0], got_ue[7:0]}), WORD_W'(16'h0100));
            chk(ce_seen && err_addr == AW'(b % DEPTH), "R10 captured address",
                WORD_W'(err_addr), WORD_W'(b % DEPTH));
            chk(err_syn == {1'b1, spos(b)}, "R10 syndrome single",
                WORD_W'(err_syn), WORD_W'({1'b1, spos(b)}));
        end

        // double-bit sweep: R4, R10
        for (int b = 0; b < WORD_W; b++) begin
            int c;
            c = (b + 29) % WORD_W;
            d = pat(b + 300);
            m = (WORD_W'(1) << b) | (WORD_W'(1) << c);
            do_req(1, b % DEPTH, d, 8'hFF);
            clear_status();
            flip(b % DEPTH, m);
            do_req(0, b % DEPTH, '0, '0);
            chk(got_err && got_ue == 1 && got_ce == 0, "R4 uncorrectable flagged",
                WORD_W'({got_err, got_ue[7:0], got_ce[7:0]}), WORD_W'(17'h10100));
            chk(ue_seen && err_syn == {1'b0, spos(b) ^ spos(c)}, "R10 syndrome double",
                WORD_W'(err_syn), WORD_W'({1'b0, spos(b) ^ spos(c)}));
        end

        // detect-only mode: R5
        corr_en = 0;
        for (int b = 0; b < WORD_W; b += 7) begin
            d = pat(b + 700);
            m = WORD_W'(1) << b;
            do_req(1, 3, d, 8'hFF);
            flip(3, m);
            do_req(0, 3, '0, '0);
            e = d ^ m[DATA_W-1:0];
            chk(got_data == e && !got_err && got_ce == 1, "R5 raw single",
                WORD_W'(got_data), WORD_W'(e));
            m = m | (WORD_W'(1) << ((b + 5) % WORD_W));
            do_req(1, 4, d, 8'hFF);
            flip(4, m);
            do_req(0, 4, '0, '0);
            e = d ^ m[DATA_W-1:0];
            chk(got_data == e && got_err && got_ue == 1 && got_ce == 0, "R5 raw double",
                WORD_W'(got_data), WORD_W'(e));
        end
        corr_en = 1;

        // partial writes as read-modify-write: R6, R9
        for (int be = 1; be < 255; be++) begin
            int a;
            bit inj;
            a = be % DEPTH;
            d = pat(be);
            n = pat(be + 500);
            do_req(1, a, d, 8'hFF);
            inj = (be % 8) == 5;
            if (inj) flip(a, WORD_W'(1) << (be % DATA_W));
            do_req(1, a, n, 8'(be));
            e = mrg(d, n, 8'(be));
            chk(got_rd == 1 && got_wr == 1 && !got_err, "R6 read then write",
                WORD_W'({got_rd[7:0], got_wr[7:0]}), WORD_W'(16'h0101));
            chk(mem_q[a] == benc(e), "R6 merged word", mem_q[a], benc(e));
            chk(got_ce == (inj ? 1 : 0), "R6 ce on corrected old word",
                WORD_W'(got_ce), WORD_W'(inj));
            chk(!got_leak, "R9 ready low during sequence", WORD_W'(got_leak), '0);
        end

        // partial write over uncorrectable old word: R7
        for (int k = 0; k < 8; k++) begin
            d = pat(k + 900);
            m = (WORD_W'(1) << k) | (WORD_W'(1) << (k + 40));
            do_req(1, k, d, 8'hFF);
            flip(k, m);
            old = benc(d) ^ m;
            do_req(1, k, pat(k + 950), 8'h0F);
            chk(got_err && got_ue == 1 && got_wr == 0, "R7 aborted write",
                WORD_W'({got_err, got_wr[7:0]}), WORD_W'(9'h100));
            chk(mem_q[k] == old, "R7 memory unchanged", mem_q[k], old);
        end

        // ECC disabled: R8
        for (int k = 0; k < 6; k++) begin
            logic [BYTES-1:0] bev;
            bev = (k == 5) ? 8'hFF : 8'(8'h13 << k);
            ecc_en = 1;
            d = pat(k + 1200);
            n = pat(k + 1300);
            do_req(1, 9, d, 8'hFF);
            ecc_en = 0;
            old = mem_q[9];
            do_req(1, 9, n, bev);
            e = mrg(d, n, bev);
            m = (bev == 8'hFF) ? benc(n) : {old[WORD_W-1:DATA_W], e};
            chk(got_rd == 0 && got_wr == 1, "R8 direct write",
                WORD_W'({got_rd[7:0], got_wr[7:0]}), WORD_W'(16'h0001));
            chk(mem_q[9] == m, "R8 lane masked store", mem_q[9], m);
            flip(9, WORD_W'(3) << (k * 9));
            m = mem_q[9];
            do_req(0, 9, '0, '0);
            chk(got_data == m[DATA_W-1:0] && !got_err && got_ce == 0 && got_ue == 0,
                "R8 unchecked read", WORD_W'(got_data), WORD_W'(m[DATA_W-1:0]));
        end
        ecc_en = 1;

        // sticky capture holds the first event, clear wipes: R10
        clear_status();
        do_req(1, 1, pat(2000), 8'hFF);
        do_req(1, 2, pat(2001), 8'hFF);
        flip(1, WORD_W'(1) << 10);
        flip(2, WORD_W'(1) << 20);
        do_req(0, 1, '0, '0);
        do_req(0, 2, '0, '0);
        chk(ce_seen && !ue_seen && err_addr == AW'(1), "R10 first event kept",
            WORD_W'(err_addr), WORD_W'(1));
        chk(err_syn == {1'b1, spos(10)}, "R10 first syndrome kept",
            WORD_W'(err_syn), WORD_W'({1'b1, spos(10)}));
        clear_status();
        chk(!ce_seen && !ue_seen, "R10 cleared", WORD_W'({ce_seen, ue_seen}), '0);

        done = 1;
        finish_up();
    end
endmodule